// File: doc/BRIEF.md
# Flash Cycle Status Tracker

This block keeps the status of flash cycles that software launches one at a time through a flash controller. A launch request is accepted only when no cycle is running and the protection checker does not object. On acceptance the block raises a busy flag and sends a one-cycle start pulse to the serial engine. When the engine reports that the cycle has finished, busy drops and a sticky completion flag is raised. A launch that is refused, or a write to the cycle-setup registers while a cycle runs, raises a sticky error flag and starts nothing.

Software reads an 8-bit status byte. It clears the completion and error flags by writing ones to their bit positions. The completion flag, gated by an enable input, drives an interrupt request. One status bit passes an external access-error indication straight through to software. The reset input is asserted asynchronously and released in step with the clock.

Top module: `flash_cycle_status`

## Requirements
- R1: While reset is held, and after it is released with no other activity, the status byte reads 0x00 (with `ael_in` low), and `cycle_busy`, `engine_start` and `irq_req` are 0.
- R2: Status byte layout: bit 0 is busy, bit 2 is done, bit 3 is error and bit 4 is the access-error mirror. Bits 1, 5, 6 and 7 always read 0, and writes to them have no effect.
- R3: A `go_req` while idle and not blocked sets busy on the next clock and pulses `engine_start` high for exactly that one cycle. Busy then holds until `cycle_fin`.
- R4: A `cycle_fin` while busy clears busy and sets done on the next clock. Done stays set afterwards. A `cycle_fin` while idle changes nothing.
- R5: A `go_req` with `prot_block` high produces no start pulse and does not set busy. It sets error on the next clock.
- R6: A `go_req` or `prog_reg_wr` while busy sets error on the next clock. It produces no start pulse and leaves busy unchanged.
- R7: A register write with bit 2 or bit 3 equal to 1 clears done or error, respectively, on the next clock. A 0 in that bit leaves the flag unchanged, and writing bit 0 does not affect busy.
- R8: If a hardware set of done or error falls in the same cycle as a software clear of that bit, the bit ends up 1.
- R9: `irq_req` is high exactly while done is 1 and `smi_en` is 1. It follows `smi_en` in the same cycle and drops on the clock that clears done.
- R10: Status bit 4 equals `ael_in` in the same cycle, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| bus_wr | input | 1 | Register write strobe to the status byte |
| bus_wdata | input | 8 | Write data; ones in bits 2 and 3 clear those flags |
| go_req | input | 1 | Launch request from the command register |
| prot_block | input | 1 | Protection checker refuses the current launch |
| prog_reg_wr | input | 1 | A cycle-setup register is being written |
| cycle_fin | input | 1 | Engine reports the running cycle complete |
| smi_en | input | 1 | Enable for the completion interrupt |
| ael_in | input | 1 | Access-error indication mirrored to status bit 4 |
| status_byte | output | 8 | Status read data |
| cycle_busy | output | 1 | Cycle in progress |
| engine_start | output | 1 | One-cycle start pulse to the serial engine |
| irq_req | output | 1 | Completion interrupt request |

## Verification
Two things can fall in one cycle. A hardware set of done or error can meet a software write-1 clear of the same bit, and a launch request can meet the engine's completion pulse. The bench provokes the first by driving `cycle_fin` together with a write of 0x04, and `prog_reg_wr` during a cycle together with a write of 0x08. The flags must read 1 afterwards. It provokes the second by driving `go_req` and `cycle_fin` in the same cycle while busy. The launch must be refused and flagged as an error, and the cycle must still complete.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int STAT_W     = 8;
  localparam int BIT_BUSY   = 0;
  localparam int BIT_DONE   = 2;
  localparam int BIT_ERR    = 3;
  localparam int BIT_AEL    = 4;
  localparam int NUM_STICKY = 2;
  localparam int IDX_DONE   = 0;
  localparam int IDX_ERR    = 1;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fcs_launch_ctrl.sv
module fcs_launch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic prot_block,
  input  logic prog_reg_wr,
  input  logic cycle_fin,
  output logic busy_o,
  output logic start_o,
  output logic fault_o,
  output logic finish_o
);
  logic busy_q, busy_d, busy_en;
  logic start_q, start_d;
  logic accept;

  always_comb begin
    accept   = go_req && !busy_q && !prot_block;
    fault_o  = (go_req && (busy_q || prot_block)) || (prog_reg_wr && busy_q);
    finish_o = cycle_fin && busy_q;
    busy_en  = accept || finish_o;
    busy_d   = accept;
    start_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (busy_en) busy_q <= busy_d;
      start_q <= start_d;
    end
  end

  assign busy_o  = busy_q;
  assign start_o = start_q;
endmodule

// File: rtl/fcs_w1c_bit.sv
module fcs_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q, d, en;

  always_comb begin
    en = set_i || clr_i;
    d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/fcs_status_pack.sv
module fcs_status_pack
  import fcs_pkg::*;
(
  input  logic              busy,
  input  logic              done,
  input  logic              err,
  input  logic              ael,
  output logic [STAT_W-1:0] byte_o
);
  always_comb begin
    byte_o           = '0;
    byte_o[BIT_BUSY] = busy;
    byte_o[BIT_DONE] = done;
    byte_o[BIT_ERR]  = err;
    byte_o[BIT_AEL]  = ael;
  end
endmodule

// File: rtl/flash_cycle_status.sv
module flash_cycle_status
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [STAT_W-1:0] bus_wdata,
  input  logic              go_req,
  input  logic              prot_block,
  input  logic              prog_reg_wr,
  input  logic              cycle_fin,
  input  logic              smi_en,
  input  logic              ael_in,
  output logic [STAT_W-1:0] status_byte,
  output logic              cycle_busy,
  output logic              engine_start,
  output logic              irq_req
);
  logic                  rst_core_n;
  logic                  fault, finish;
  logic [NUM_STICKY-1:0] set_vec, clr_vec, flag_vec;

  fcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  fcs_launch_ctrl u_launch (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .go_req      (go_req),
    .prot_block  (prot_block),
    .prog_reg_wr (prog_reg_wr),
    .cycle_fin   (cycle_fin),
    .busy_o      (cycle_busy),
    .start_o     (engine_start),
    .fault_o     (fault),
    .finish_o    (finish)
  );

  always_comb begin
    set_vec[IDX_DONE] = finish;
    set_vec[IDX_ERR]  = fault;
    clr_vec[IDX_DONE] = bus_wr && bus_wdata[BIT_DONE];
    clr_vec[IDX_ERR]  = bus_wr && bus_wdata[BIT_ERR];
  end

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    fcs_w1c_bit u_bit (
      .clk   (clk),
      .rst_n (rst_core_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flag_vec[i])
    );
  end

  fcs_status_pack u_pack (
    .busy   (cycle_busy),
    .done   (flag_vec[IDX_DONE]),
    .err    (flag_vec[IDX_ERR]),
    .ael    (ael_in),
    .byte_o (status_byte)
  );

  assign irq_req = flag_vec[IDX_DONE] && smi_en;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
(
  input logic              clk,
  input logic              rst_core_n,
  input logic              bus_wr,
  input logic [STAT_W-1:0] bus_wdata,
  input logic              go_req,
  input logic              prot_block,
  input logic              prog_reg_wr,
  input logic              cycle_fin,
  input logic [STAT_W-1:0] status_byte,
  input logic              cycle_busy,
  input logic              engine_start,
  input logic              irq_req
);
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_core_n)
    cycle_busy && !cycle_fin |=> cycle_busy);

  a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_core_n)
    engine_start |-> cycle_busy && !$past(cycle_busy));

  a_r4_done_on_finish: assert property (@(posedge clk) disable iff (!rst_core_n)
    cycle_busy && cycle_fin |=> !cycle_busy && status_byte[BIT_DONE]);

  a_r5_block_flags_error: assert property (@(posedge clk) disable iff (!rst_core_n)
    go_req && prot_block |=> status_byte[BIT_ERR] && !engine_start);

  a_r6_busy_write_error: assert property (@(posedge clk) disable iff (!rst_core_n)
    prog_reg_wr && cycle_busy |=> status_byte[BIT_ERR]);

  a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_wr && bus_wdata[BIT_DONE] && !(cycle_busy && cycle_fin) |=> !status_byte[BIT_DONE]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_core_n)
    cycle_busy && cycle_fin && bus_wr && bus_wdata[BIT_DONE] |=> status_byte[BIT_DONE]);

  a_r9_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_req |-> status_byte[BIT_DONE]);
endmodule

bind flash_cycle_status fcs_checker u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .bus_wr       (bus_wr),
  .bus_wdata    (bus_wdata),
  .go_req       (go_req),
  .prot_block   (prot_block),
  .prog_reg_wr  (prog_reg_wr),
  .cycle_fin    (cycle_fin),
  .status_byte  (status_byte),
  .cycle_busy   (cycle_busy),
  .engine_start (engine_start),
  .irq_req      (irq_req)
);

// File: tb/flash_cycle_status_tb.sv
module flash_cycle_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       go_req = 1'b0, prot_block = 1'b0, prog_reg_wr = 1'b0, cycle_fin = 1'b0;
  logic       smi_en = 1'b0, ael_in = 1'b0;
  logic [7:0] status_byte;
  logic       cycle_busy, engine_start, irq_req;

  int checks = 0;
  int errors = 0;

  // expected item: {status[7:0], busy, start, irq}
  logic [10:0] exp_q[$];
  string       tag_q[$];

  // bench-side model of the requirements
  logic m_busy = 1'b0, m_done = 1'b0, m_err = 1'b0;

  always #2.5 clk = ~clk;

  flash_cycle_status u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .go_req(go_req), .prot_block(prot_block), .prog_reg_wr(prog_reg_wr),
    .cycle_fin(cycle_fin), .smi_en(smi_en), .ael_in(ael_in),
    .status_byte(status_byte), .cycle_busy(cycle_busy),
    .engine_start(engine_start), .irq_req(irq_req)
  );

  task automatic compare(input logic [10:0] act, input logic [10:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual status=%02h busy=%b start=%b irq=%b expected status=%02h busy=%b start=%b irq=%b",
               tag, act[10:3], act[2], act[1], act[0], exp[10:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // driver: applies one cycle of stimulus and predicts the state after the edge
  task automatic step(input logic go, input logic prot, input logic prog, input logic fin,
                      input logic wr, input logic [7:0] wd, input logic smi, input logic ael,
                      input string tag);
    logic accept, fault, finish;
    @(negedge clk);
    go_req = go; prot_block = prot; prog_reg_wr = prog; cycle_fin = fin;
    bus_wr = wr; bus_wdata = wd; smi_en = smi; ael_in = ael;
    accept = go && !m_busy && !prot;
    fault  = (go && (m_busy || prot)) || (prog && m_busy);
    finish = fin && m_busy;
    if (accept) m_busy = 1'b1;
    else if (finish) m_busy = 1'b0;
    m_done = finish || (m_done && !(wr && wd[2]));
    m_err  = fault  || (m_err  && !(wr && wd[3]));
    exp_q.push_back({3'b000, ael, m_err, m_done, 1'b0, m_busy, m_busy, accept, m_done && smi});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic smi, input logic ael, input string tag);
    step(0, 0, 0, 0, 0, 8'h00, smi, ael, tag);
  endtask

  // monitor: compares each expected item one step after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      logic [10:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compare({status_byte, cycle_busy, engine_start, irq_req}, e, t);
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3;
    compare({status_byte, cycle_busy, engine_start, irq_req}, 11'h000, "R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare({status_byte, cycle_busy, engine_start, irq_req}, 11'h000, "R1 after release");

    // R10 and R2: mirror and reserved bits
    idle(0, 1, "R10 mirror high");
    step(0, 0, 0, 0, 1, 8'hFF, 0, 0, "R2 write all ones idle");
    step(0, 0, 0, 0, 1, 8'hE3, 0, 0, "R2 reserved and busy write");

    // R3 launch
    step(1, 0, 0, 0, 0, 8'h00, 0, 0, "R3 launch");
    idle(0, 0, "R3 start single pulse");
    idle(0, 0, "R3 busy holds");
    step(0, 0, 0, 0, 1, 8'h01, 0, 0, "R7 busy bit write ignored");

    // R6 errors while busy
    step(0, 0, 1, 0, 0, 8'h00, 0, 0, "R6 prog write while busy");
    step(0, 0, 0, 0, 1, 8'h00, 0, 0, "R7 write zero keeps error");
    step(0, 0, 0, 0, 1, 8'h08, 0, 0, "R7 clear error");
    step(1, 0, 0, 0, 0, 8'h00, 0, 0, "R6 go while busy");

    // R4 completion, R9 interrupt
    step(0, 0, 0, 1, 0, 8'h00, 0, 0, "R4 finish");
    idle(0, 0, "R4 done sticky");
    idle(1, 0, "R9 irq follows enable");
    step(0, 0, 0, 0, 1, 8'h04, 1, 0, "R9 irq drops on clear");
    step(0, 0, 0, 1, 0, 8'h00, 1, 0, "R4 finish while idle ignored");
    step(0, 0, 0, 0, 1, 8'h08, 0, 0, "R7 clear error again");

    // R5 protection block
    step(1, 1, 0, 0, 0, 8'h00, 0, 0, "R5 blocked launch");
    idle(0, 0, "R5 no busy after block");
    step(0, 0, 0, 0, 1, 8'h08, 0, 0, "R7 clear after block");

    // R8 set beats clear
    step(1, 0, 0, 0, 0, 8'h00, 1, 1, "R3 second launch");
    step(0, 0, 1, 0, 1, 8'h08, 1, 1, "R8 error set vs clear");
    step(1, 0, 0, 1, 1, 8'h04, 1, 0, "R8 done set vs clear with go");
    idle(1, 0, "R8 done held");
    step(0, 0, 0, 0, 1, 8'h0C, 1, 1, "R7 clear both");
    idle(0, 0, "R9 enable low");
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule